// File: doc/BRIEF.md
# Pointer-Indexed Dual-FIFO Host Register Port

This block is the host-facing register window of a controller that moves bytes in both directions between a host and a board through two FIFOs. The host sees only a few byte addresses: a data address, a shared control address, and a reset address. Most internal registers sit behind the shared control address. The host first writes a register code there, and the following access at that address reaches the chosen register. After that one access the address goes back to loading codes.

The two FIFOs are modelled as occupancy counters with full and empty flags. The host side writes into the outbound FIFO and reads from the inbound FIFO. The board side uses single-cycle strobes to push inbound bytes and pop outbound bytes. The port also has two one-byte mailboxes, a shared threshold byte for the almost-empty and almost-full flags, an interrupt mask, a sticky reset-occurred flag and a gated host interrupt. The byte-match and parity conditions are stub inputs that pass straight into the status byte.

Top module: `dual_fifo_host_port`

## Requirements
- R1: After reset the host interrupt and the board reset pulse are low, both FIFOs are empty, the register window is in code-loading mode, and a status read returns 0xA8.
- R2: A host write at offset 2 in code-loading mode stores bits [2:0] as the register code. Exactly the next read or write at offset 2 reaches that register, and the window then returns to code-loading mode. Accesses at any other offset do not use up the armed code. Codes 0 and 7 select nothing: reads return 0x00 and writes are dropped.
- R3: Register codes are 1 command, 2 interrupt mask, 3 match byte, 4 outbound mailbox, 5 threshold and 6 inbound mailbox. The mask, match byte and threshold read back the value last written.
- R4: The status byte read at offset 2 in code-loading mode has these bits: bit7 reset occurred, bit6 outbound full, bit5 inbound empty, bit4 outbound almost full, bit3 inbound almost empty, bit2 inbound mailbox full, bit1 byte match input, bit0 parity input.
- R5: The reset-occurred bit is set by any reset. Only a status read clears it; register reads do not. All other status bits follow their live conditions.
- R6: Command 0x40 swaps the status view to the board side's flags: bit6 inbound full, bit5 outbound empty, bit4 inbound almost full, bit3 outbound almost empty, bit2 outbound mailbox full. Command 0x00 restores the normal view. Reading the command register returns 0x40 while swapped and 0x00 otherwise. Other command values have no effect.
- R7: Command 0x80 and any host write at offset 7 both put every register, counter and flag back in its reset state. A write at offset 7 also drives brd_rst high for exactly the next cycle.
- R8: A host write at offset 0 adds one entry to the outbound FIFO unless it is full. A host read at offset 0 returns 0x00 and removes one entry from the inbound FIFO unless it is empty. The board-side push and pop strobes act on the inbound and outbound FIFOs under the same full and empty limits.
- R9: With threshold byte T, outbound almost full holds when occupancy + T >= DEPTH, and inbound almost empty holds when occupancy <= T.
- R10: A host write to the outbound mailbox stores the byte and raises brd_obx_full. A board read strobe then clears both the stored byte and the flag, so a later readback returns 0x00.
- R11: A board mailbox write stores the byte and sets status bit2. A host read of the inbound mailbox returns the byte and clears bit2. A board write in the same cycle wins.
- R12: The interrupt mask keeps bits [6:0] and bit7 always reads back 0. host_irq = enable AND (reset-occurred OR any normal-view status bit [6:0] that is also set in the mask). The board's enable strobe sets the enable, and any reset clears it.
- R13: Reads at offset 7 and any access at offsets 1 and 3 to 6 return 0x00 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 3 | Host byte offset |
| hst_wr | input | 1 | Host write strobe, one per cycle |
| hst_rd | input | 1 | Host read strobe; ignored when hst_wr is high |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid in the cycle of hst_rd |
| host_irq | output | 1 | Host interrupt |
| brd_push | input | 1 | Board adds an inbound entry |
| brd_pop | input | 1 | Board removes an outbound entry |
| brd_mbox_wr | input | 1 | Board writes the inbound mailbox |
| brd_mbox_wdata | input | 8 | Inbound mailbox byte |
| brd_mbox_rd | input | 1 | Board consumes the outbound mailbox |
| brd_irq_en | input | 1 | Board enables the host interrupt |
| brd_byte_match | input | 1 | Byte-match stub condition |
| brd_parity | input | 1 | Parity stub condition |
| brd_obx_data | output | 8 | Outbound mailbox byte |
| brd_obx_full | output | 1 | Outbound mailbox holds unread data |
| brd_rst | output | 1 | One-cycle board reset pulse |

## Verification
The bench builds the port with DEPTH set to 16 instead of 512. This makes filling the outbound FIFO to its limit, writing once more while full, and stepping occupancy across both threshold edges short sequences. A threshold of 3 places the almost-full edge at 13 and the almost-empty edge at 3, and the bench checks both sides of each edge. A behavioural model built from integers follows every clock and checks the interrupt, the board reset pulse and the outbound mailbox outputs on each cycle.

// File: rtl/dfhp_pkg.sv
// Package: shared codes and bit positions for the dual-FIFO host port.
// Assumes: 3-bit host offsets and an 8-bit status byte.
package dfhp_pkg;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CMD   = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_MATCH = 3'd3,
        SEL_OMBX  = 3'd4,
        SEL_THR   = 3'd5,
        SEL_IMBX  = 3'd6,
        SEL_SPARE = 3'd7
    } reg_sel_e;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_RST  = 3'd7;

    localparam logic [7:0] CMD_RESET  = 8'h80;
    localparam logic [7:0] CMD_SWAP   = 8'h40;
    localparam logic [7:0] CMD_NORMAL = 8'h00;

    localparam int ST_MR     = 7;
    localparam int ST_FULL   = 6;
    localparam int ST_EMPTY  = 5;
    localparam int ST_AFULL  = 4;
    localparam int ST_AEMPTY = 3;
    localparam int ST_MBOX   = 2;
    localparam int ST_MATCH  = 1;
    localparam int ST_PAR    = 0;

endpackage

// File: rtl/dfhp_occ_counter.sv
// Module: occupancy counter that stands in for one FIFO direction.
// Assumes: inc and dec are single-cycle strobes. An increment is dropped
// when full and a decrement is dropped when empty. clr acts like reset.
module dfhp_occ_counter #(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);

    logic take_inc;
    logic take_dec;

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign take_inc = inc && !full;
    assign take_dec = dec && !empty;

    // Occupancy update: net change of accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (take_inc && !take_dec) begin
            cnt <= cnt + 1'b1;
        end else if (take_dec && !take_inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R8: a push into a full FIFO keeps it full, with no wrap.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && inc && !dec && !clr) |=> full);

    // R8: a pop from an empty FIFO keeps it empty, with no wrap.
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && dec && !inc && !clr) |=> empty);

    // R8: occupancy never exceeds the depth.
    p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/dfhp_access_decode.sv
// Module: host access decoder with the one-shot register-code window.
// Assumes: at most one host strobe is meaningful per cycle, and a write
// takes precedence over a read. clr returns the window to code-loading mode.
module dfhp_access_decode
    import dfhp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic [2:0] addr,
    input  logic     wr,
    input  logic     rd,
    input  logic [2:0] code_in,
    output logic     data_wr,
    output logic     data_rd,
    output logic     stat_rd,
    output logic     reg_wr,
    output logic     reg_rd,
    output logic     rst_wr,
    output reg_sel_e sel
);

    logic armed;
    logic rd_only;
    logic at_ctrl;
    logic code_wr;

    assign rd_only = rd && !wr;
    assign at_ctrl = (addr == OFS_CTRL);
    assign data_wr = wr && (addr == OFS_DATA);
    assign data_rd = rd_only && (addr == OFS_DATA);
    assign stat_rd = rd_only && at_ctrl && !armed;
    assign code_wr = wr && at_ctrl && !armed;
    assign reg_wr  = wr && at_ctrl && armed;
    assign reg_rd  = rd_only && at_ctrl && armed;
    assign rst_wr  = wr && (addr == OFS_RST);

    // Window state: arm on a code write, disarm after the one register access.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed <= 1'b0;
            sel   <= SEL_NONE;
        end else if (code_wr) begin
            armed <= 1'b1;
            sel   <= reg_sel_e'(code_in);
        end else if (reg_wr || reg_rd) begin
            armed <= 1'b0;
        end
    end

    // R2: a code write arms the window.
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr |=> armed);

    // R2: exactly one register access is redirected.
    p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> !armed);

    // R13: other offsets leave the window state alone.
    p_other_ofs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_ctrl && !rst_wr) |=> $stable(armed));

endmodule

// File: rtl/dfhp_status_irq.sv
// Module: status byte composer, sticky reset flag and interrupt gate.
// Assumes: counts come from the occupancy counters. thr is the shared
// threshold byte. The interrupt always looks at the normal, unswapped view.
module dfhp_status_irq
    import dfhp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          stat_rd,
    input  logic          ien_set,
    input  logic [CW-1:0] in_cnt,
    input  logic [CW-1:0] out_cnt,
    input  logic          in_full,
    input  logic          in_empty,
    input  logic          out_full,
    input  logic          out_empty,
    input  logic [7:0]    thr,
    input  logic          swap,
    input  logic          ibf,
    input  logic          obf,
    input  logic          match,
    input  logic          parity,
    input  logic [6:0]    mask,
    output logic [7:0]    status_view,
    output logic          irq
);

    logic       mr;
    logic       ien;
    logic       out_af, in_ae, in_af, out_ae;
    logic [7:0] normal_v;
    logic [7:0] swapped_v;

    // Sticky reset-occurred flag: set by any reset, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mr <= 1'b1;
        end else if (stat_rd) begin
            mr <= 1'b0;
        end
    end

    // Global interrupt enable: cleared by any reset, set by the board.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ien <= 1'b0;
        end else if (ien_set) begin
            ien <= 1'b1;
        end
    end

    // Threshold comparisons against the shared threshold byte.
    always_comb begin
        out_af = (int'(out_cnt) + int'(thr)) >= DEPTH;
        in_af  = (int'(in_cnt) + int'(thr)) >= DEPTH;
        in_ae  = int'(in_cnt) <= int'(thr);
        out_ae = int'(out_cnt) <= int'(thr);
    end

    // Both status views and the selected one.
    always_comb begin
        normal_v            = '0;
        normal_v[ST_MR]     = mr;
        normal_v[ST_FULL]   = out_full;
        normal_v[ST_EMPTY]  = in_empty;
        normal_v[ST_AFULL]  = out_af;
        normal_v[ST_AEMPTY] = in_ae;
        normal_v[ST_MBOX]   = ibf;
        normal_v[ST_MATCH]  = match;
        normal_v[ST_PAR]    = parity;
        swapped_v            = normal_v;
        swapped_v[ST_FULL]   = in_full;
        swapped_v[ST_EMPTY]  = out_empty;
        swapped_v[ST_AFULL]  = in_af;
        swapped_v[ST_AEMPTY] = out_ae;
        swapped_v[ST_MBOX]   = obf;
        status_view = swap ? swapped_v : normal_v;
    end

    // Interrupt gate: unmaskable reset flag plus masked live bits.
    assign irq = ien && (mr || (|(normal_v[6:0] & mask)));

    // R5: a status read clears the reset-occurred flag.
    p_mr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !soft_rst) |=> !mr);

    // R7: a soft reset sets the reset-occurred flag.
    p_mr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> mr);

    // R12: the interrupt is quiet in the cycle after any soft reset.
    p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq);

endmodule

// File: rtl/dual_fifo_host_port.sv
// Module: top of the pointer-indexed dual-FIFO host port.
// Assumes: host strobes are single-cycle and read data is taken in the
// strobe cycle. Board strobes are single-cycle. Soft resets (command
// 0x80 or a write at offset 7) act like rst_n on all state.
module dual_fifo_host_port
    import dfhp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NDIR = 2,
    localparam int DIR_IN = 0,
    localparam int DIR_OUT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hst_addr,
    input  logic       hst_wr,
    input  logic       hst_rd,
    input  logic [7:0] hst_wdata,
    output logic [7:0] hst_rdata,
    output logic       host_irq,
    input  logic       brd_push,
    input  logic       brd_pop,
    input  logic       brd_mbox_wr,
    input  logic [7:0] brd_mbox_wdata,
    input  logic       brd_mbox_rd,
    input  logic       brd_irq_en,
    input  logic       brd_byte_match,
    input  logic       brd_parity,
    output logic [7:0] brd_obx_data,
    output logic       brd_obx_full,
    output logic       brd_rst
);

    logic     data_wr, data_rd, stat_rd, reg_wr, reg_rd, rst_wr;
    reg_sel_e sel;
    logic     soft_rst;
    logic     obx_load;

    logic [CW-1:0] occ   [NDIR];
    logic          full  [NDIR];
    logic          empty [NDIR];
    logic          inc   [NDIR];
    logic          dec   [NDIR];

    logic       swap;
    logic [6:0] mask;
    logic [7:0] match_ref;
    logic [7:0] thr;
    logic [7:0] obm;
    logic       obf;
    logic [7:0] ibm;
    logic       ibf;
    logic [7:0] status_view;
    logic       brd_rst_q;

    dfhp_access_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .addr    (hst_addr),
        .wr      (hst_wr),
        .rd      (hst_rd),
        .code_in (hst_wdata[2:0]),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .stat_rd (stat_rd),
        .reg_wr  (reg_wr),
        .reg_rd  (reg_rd),
        .rst_wr  (rst_wr),
        .sel     (sel)
    );

    assign soft_rst = rst_wr || (reg_wr && (sel == SEL_CMD) && (hst_wdata == CMD_RESET));
    assign obx_load = reg_wr && (sel == SEL_OMBX);

    assign inc[DIR_IN]  = brd_push;
    assign dec[DIR_IN]  = data_rd;
    assign inc[DIR_OUT] = data_wr;
    assign dec[DIR_OUT] = brd_pop;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dfhp_occ_counter #(.DEPTH(DEPTH)) u_occ (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_rst),
            .inc   (inc[d]),
            .dec   (dec[d]),
            .cnt   (occ[d]),
            .full  (full[d]),
            .empty (empty[d])
        );
    end

    // Control registers written through the window.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            swap      <= 1'b0;
            mask      <= '0;
            match_ref <= '0;
            thr       <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_CMD: begin
                    if (hst_wdata == CMD_SWAP) begin
                        swap <= 1'b1;
                    end else if (hst_wdata == CMD_NORMAL) begin
                        swap <= 1'b0;
                    end
                end
                SEL_MASK:  mask      <= hst_wdata[6:0];
                SEL_MATCH: match_ref <= hst_wdata;
                SEL_THR:   thr       <= hst_wdata;
                default: ;
            endcase
        end
    end

    // Outbound mailbox: host loads it, board consumption zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            obm <= '0;
            obf <= 1'b0;
        end else if (obx_load) begin
            obm <= hst_wdata;
            obf <= 1'b1;
        end else if (brd_mbox_rd) begin
            obm <= '0;
            obf <= 1'b0;
        end
    end

    // Inbound mailbox: board loads it, host read clears the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ibm <= '0;
            ibf <= 1'b0;
        end else if (brd_mbox_wr) begin
            ibm <= brd_mbox_wdata;
            ibf <= 1'b1;
        end else if (reg_rd && (sel == SEL_IMBX)) begin
            ibf <= 1'b0;
        end
    end

    // Board reset pulse: one cycle after a write at the reset offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brd_rst_q <= 1'b0;
        end else begin
            brd_rst_q <= rst_wr;
        end
    end

    dfhp_status_irq #(.DEPTH(DEPTH)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .stat_rd     (stat_rd),
        .ien_set     (brd_irq_en),
        .in_cnt      (occ[DIR_IN]),
        .out_cnt     (occ[DIR_OUT]),
        .in_full     (full[DIR_IN]),
        .in_empty    (empty[DIR_IN]),
        .out_full    (full[DIR_OUT]),
        .out_empty   (empty[DIR_OUT]),
        .thr         (thr),
        .swap        (swap),
        .ibf         (ibf),
        .obf         (obf),
        .match       (brd_byte_match),
        .parity      (brd_parity),
        .mask        (mask),
        .status_view (status_view),
        .irq         (host_irq)
    );

    // Host read data multiplexer.
    always_comb begin
        hst_rdata = '0;
        if (stat_rd) begin
            hst_rdata = status_view;
        end else if (reg_rd) begin
            case (sel)
                SEL_CMD:   hst_rdata = swap ? CMD_SWAP : CMD_NORMAL;
                SEL_MASK:  hst_rdata = {1'b0, mask};
                SEL_MATCH: hst_rdata = match_ref;
                SEL_OMBX:  hst_rdata = obm;
                SEL_THR:   hst_rdata = thr;
                SEL_IMBX:  hst_rdata = ibm;
                default:   hst_rdata = '0;
            endcase
        end
    end

    assign brd_obx_data = obm;
    assign brd_obx_full = obf;
    assign brd_rst      = brd_rst_q;

    // R7: the board reset pulse only follows a write at the reset offset.
    p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brd_rst |-> $past(hst_wr && (hst_addr == OFS_RST)));

    // R10: board consumption leaves the outbound mailbox zero and empty.
    p_mbox_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_mbox_rd && !obx_load) |=> (brd_obx_data == 8'h00 && !brd_obx_full));

    // R11: a board mailbox write always leaves the inbound flag set.
    p_mbox_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_mbox_wr && !soft_rst) |=> ibf);

endmodule

// File: tb/tb_dual_fifo_host_port.sv
// Bench: directed host and board stimulus, with a behavioural model
// compared on every clock for irq, board reset and outbound mailbox.
module tb_dual_fifo_host_port;

    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] a = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] hst_rdata;
    logic       host_irq;
    logic       b_push = 0, b_pop = 0, b_mbwr = 0, b_mbrd = 0, b_ien = 0;
    logic       b_match = 0, b_par = 0;
    logic [7:0] b_mbdata = '0;
    logic [7:0] brd_obx_data;
    logic       brd_obx_full, brd_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dual_fifo_host_port #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(a), .hst_wr(wr), .hst_rd(rd),
        .hst_wdata(wd), .hst_rdata(hst_rdata), .host_irq(host_irq),
        .brd_push(b_push), .brd_pop(b_pop), .brd_mbox_wr(b_mbwr),
        .brd_mbox_wdata(b_mbdata), .brd_mbox_rd(b_mbrd), .brd_irq_en(b_ien),
        .brd_byte_match(b_match), .brd_parity(b_par),
        .brd_obx_data(brd_obx_data), .brd_obx_full(brd_obx_full), .brd_rst(brd_rst)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state.
    int m_in, m_out, m_thr;
    bit m_mr, m_ien, m_shift, m_obf, m_ibf, m_armed, m_brst;
    int m_sel;
    logic [6:0] m_mask;
    logic [7:0] m_obm;

    task automatic m_clear();
        m_in = 0; m_out = 0; m_thr = 0; m_mr = 1; m_ien = 0; m_shift = 0;
        m_obf = 0; m_ibf = 0; m_armed = 0; m_sel = 0; m_mask = '0; m_obm = '0;
    endtask

    function automatic bit m_irq();
        bit [6:0] st;
        st[6] = (m_out == D);
        st[5] = (m_in == 0);
        st[4] = (m_out + m_thr >= D);
        st[3] = (m_in <= m_thr);
        st[2] = m_ibf;
        st[1] = b_match;
        st[0] = b_par;
        return m_ien && (m_mr || ((st & m_mask) != 0));
    endfunction

    // Model step at each rising edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear();
            m_brst = 0;
        end else begin
            bit rdv, sreset, hit_reg_wr, hit_reg_rd;
            rdv = rd && !wr;
            hit_reg_wr = wr && a == 3'd2 && m_armed;
            hit_reg_rd = rdv && a == 3'd2 && m_armed;
            sreset = (wr && a == 3'd7) || (hit_reg_wr && m_sel == 1 && wd == 8'h80);
            if (sreset) begin
                m_clear();
            end else begin
                if (b_push && m_in < D && !(rdv && a == 3'd0 && m_in > 0)) m_in++;
                else if (!b_push && rdv && a == 3'd0 && m_in > 0) m_in--;
                else if (b_push && m_in == D && rdv && a == 3'd0) m_in--;
                if (wr && a == 3'd0 && m_out < D && !(b_pop && m_out > 0)) m_out++;
                else if (!(wr && a == 3'd0) && b_pop && m_out > 0) m_out--;
                else if (wr && a == 3'd0 && m_out == D && b_pop) m_out--;
                if (rdv && a == 3'd2 && !m_armed) m_mr = 0;
                if (b_ien) m_ien = 1;
                if (hit_reg_wr) begin
                    case (m_sel)
                        1: if (wd == 8'h40) m_shift = 1; else if (wd == 8'h00) m_shift = 0;
                        2: m_mask = wd[6:0];
                        5: m_thr = int'(wd);
                        default: ;
                    endcase
                end
                if (hit_reg_wr && m_sel == 4) begin m_obm = wd; m_obf = 1; end
                else if (b_mbrd) begin m_obm = '0; m_obf = 0; end
                if (b_mbwr) m_ibf = 1;
                else if (hit_reg_rd && m_sel == 6) m_ibf = 0;
                if (wr && a == 3'd2 && !m_armed) begin m_armed = 1; m_sel = int'(wd[2:0]); end
                else if (hit_reg_wr || hit_reg_rd) m_armed = 0;
            end
            m_brst = wr && a == 3'd7;
        end
    end

    // Per-clock comparison of outputs the model predicts.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (host_irq !== m_irq()) begin
                errors++;
                $display("FAIL R12 host_irq act=%0b exp=%0b t=%0t", host_irq, m_irq(), $time);
            end
            checks++;
            if (brd_rst !== m_brst) begin
                errors++;
                $display("FAIL R7 brd_rst act=%0b exp=%0b t=%0t", brd_rst, m_brst, $time);
            end
            checks++;
            if (brd_obx_data !== m_obm || brd_obx_full !== m_obf) begin
                errors++;
                $display("FAIL R10 obx act=%h/%0b exp=%h/%0b t=%0t",
                         brd_obx_data, brd_obx_full, m_obm, m_obf, $time);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=0x%h exp=0x%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic hwr(input logic [2:0] ad, input logic [7:0] d);
        a = ad; wd = d; wr = 1; step(); wr = 0;
    endtask

    task automatic hrd(input logic [2:0] ad, input logic [7:0] exp, input string tag);
        a = ad; rd = 1; #1; chk(hst_rdata, exp, tag); step(); rd = 0;
    endtask

    task automatic push_in(input int n);
        for (int i = 0; i < n; i++) begin b_push = 1; step(); b_push = 0; end
    endtask

    task automatic pop_out(input int n);
        for (int i = 0; i < n; i++) begin b_pop = 1; step(); b_pop = 0; end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk({7'b0, host_irq}, 8'h00, "R1 irq after reset");
        chk({7'b0, brd_rst}, 8'h00, "R1 brd_rst after reset");
        hrd(3'd2, 8'hA8, "R1 reset status");
        hrd(3'd2, 8'h28, "R5 status read clears reset flag");

        hwr(3'd2, 8'd5); hwr(3'd2, 8'h03);
        hwr(3'd2, 8'd5);
        hrd(3'd0, 8'h00, "R8 empty data read");
        hrd(3'd2, 8'h03, "R2 R3 threshold via window");
        hrd(3'd2, 8'h28, "R2 back to code mode");
        hwr(3'd2, 8'd3); hwr(3'd2, 8'h5A); hwr(3'd2, 8'd3);
        hrd(3'd2, 8'h5A, "R3 match byte readback");
        hwr(3'd2, 8'd7); hwr(3'd2, 8'h55);
        hrd(3'd2, 8'h28, "R2 code 7 consumed and dropped");

        for (int i = 0; i < D + 1; i++) hwr(3'd0, 8'hEE);
        hrd(3'd2, 8'h78, "R8 R9 outbound full");
        pop_out(3);
        hrd(3'd2, 8'h38, "R9 almost full at 13");
        pop_out(1);
        hrd(3'd2, 8'h28, "R9 almost full off at 12");
        push_in(5);
        hrd(3'd2, 8'h00, "R9 inbound above threshold");
        hrd(3'd0, 8'h00, "R8 data read");
        hrd(3'd2, 8'h00, "R9 inbound 4 not almost empty");
        hrd(3'd0, 8'h00, "R8 data read");
        hrd(3'd2, 8'h08, "R9 inbound 3 almost empty");

        b_mbdata = 8'hC4; b_mbwr = 1; step(); b_mbwr = 0;
        hrd(3'd2, 8'h0C, "R11 inbound mailbox flag");
        hwr(3'd2, 8'd4); hwr(3'd2, 8'h9C);
        hwr(3'd2, 8'd1); hwr(3'd2, 8'h40);
        hrd(3'd2, 8'h04, "R6 swapped view");
        hwr(3'd2, 8'd1);
        hrd(3'd2, 8'h40, "R6 command readback");
        hwr(3'd2, 8'd1); hwr(3'd2, 8'h00);
        hrd(3'd2, 8'h0C, "R6 normal view restored");

        hwr(3'd2, 8'd4);
        hrd(3'd2, 8'h9C, "R10 outbound mailbox readback");
        b_mbrd = 1; step(); b_mbrd = 0;
        hwr(3'd2, 8'd4);
        hrd(3'd2, 8'h00, "R10 consumed reads zero");
        hwr(3'd2, 8'd6);
        hrd(3'd2, 8'hC4, "R11 inbound mailbox read");
        hrd(3'd2, 8'h08, "R11 flag cleared by read");

        hwr(3'd2, 8'd2); hwr(3'd2, 8'hFF); hwr(3'd2, 8'd2);
        hrd(3'd2, 8'h7F, "R12 mask bit7 not kept");
        chk({7'b0, host_irq}, 8'h00, "R12 disabled irq");
        b_ien = 1; step(); b_ien = 0;
        chk({7'b0, host_irq}, 8'h01, "R12 enabled irq");
        hwr(3'd2, 8'd2); hwr(3'd2, 8'h04);
        chk({7'b0, host_irq}, 8'h00, "R12 masked off");
        b_mbdata = 8'h11; b_mbwr = 1; step(); b_mbwr = 0;
        chk({7'b0, host_irq}, 8'h01, "R12 mailbox irq");
        hwr(3'd2, 8'd6);
        hrd(3'd2, 8'h11, "R11 second mailbox byte");
        chk({7'b0, host_irq}, 8'h00, "R12 irq drops");

        b_par = 1;
        hrd(3'd2, 8'h09, "R4 parity bit");
        b_match = 1;
        hrd(3'd2, 8'h0B, "R4 match bit");
        b_par = 0; b_match = 0;

        hwr(3'd2, 8'd1); hwr(3'd2, 8'h80);
        hrd(3'd2, 8'hA8, "R7 command reset status");
        hwr(3'd2, 8'd5);
        hrd(3'd2, 8'h00, "R7 threshold cleared");
        hwr(3'd2, 8'd2);
        hrd(3'd2, 8'h00, "R7 mask cleared");
        hrd(3'd2, 8'h28, "R5 flag cleared again");

        hwr(3'd7, 8'h00);
        chk({7'b0, brd_rst}, 8'h01, "R7 board pulse high");
        b_ien = 1; step(); b_ien = 0;
        chk({7'b0, brd_rst}, 8'h00, "R7 board pulse one cycle");
        chk({7'b0, host_irq}, 8'h01, "R12 reset flag interrupts");
        hrd(3'd2, 8'hA8, "R7 offset 7 reset status");
        chk({7'b0, host_irq}, 8'h00, "R12 reset flag cleared");

        hwr(3'd2, 8'd5);
        hrd(3'd7, 8'h00, "R13 offset 7 read");
        hrd(3'd3, 8'h00, "R13 offset 3 read");
        hwr(3'd3, 8'hFF);
        hwr(3'd2, 8'h07);
        hwr(3'd2, 8'd5);
        hrd(3'd2, 8'h07, "R13 R2 window survived other offsets");
        hrd(3'd2, 8'h28, "R13 status unchanged");

        hrd(3'd0, 8'h00, "R8 read of empty inbound");
        push_in(1);
        hrd(3'd2, 8'h08, "R8 no underflow");
        pop_out(1);
        hwr(3'd2, 8'd1); hwr(3'd2, 8'h40);
        hrd(3'd2, 8'h28, "R6 R8 outbound still empty");

        step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule